// File: doc/BRIEF.md
# Run-Length Infrared Remote Frame Decoder

This block turns the run-length records of one captured infrared packet into a 32-bit remote-control code. Each record carries a level bit (1 = carrier present, called a mark; 0 = no carrier, called a gap) and a duration field holding the number of sample ticks minus one. Records are offered one per cycle with a valid/ready handshake. Records of the same level that follow each other are added together, so a long period may arrive split across several records.

The decoder looks for a long leading mark, then a long leading gap, and then reads 32 mark/gap pairs. Each data mark must be short. The length of the gap that follows sets the bit value. Bits fill the code from bit 0 upward. When the 32nd bit is taken, the decoder checks that the command byte (bits 23:16) is the exact bit complement of bits 31:24 and reports the result. A one-cycle packet-start pulse clears the decoder for the next packet. A one-cycle packet-end pulse tells it that no more records will come.

The control is one state machine with five states. LEAD_MARK sums the leading mark. LEAD_GAP sums the leading gap. BIT_MARK sums a data mark. BIT_GAP sums a data gap. DONE holds the result. The transitions are:
- lead_ok: LEAD_MARK to LEAD_GAP.
- gap_ok: LEAD_GAP to BIT_MARK.
- mark_ok: BIT_MARK to BIT_GAP.
- bit_taken: BIT_GAP to BIT_MARK.
- word_full: BIT_GAP to DONE.
- fail: any active state to DONE.
- restart: any state to LEAD_MARK, on packet start.

Top module: `nec_runlen_decoder`

## Requirements
- R1: After reset, and on the cycle after a packet-start pulse, `done`, `code_ok` and `code_err` are 0, `code` is 0 and `rec_ready` is 1.
- R2: Consecutive accepted records of the same level add up as (rec_dur + 1) ticks each, and together form one mark or gap.
- R3: The leading-mark sum starts at 80 ticks, so any mark record meets the leading-mark test (sum > 80). If the first record of a packet is a gap, the frame fails.
- R4: The leading gap must total more than 40 ticks when the next mark arrives. 40 ticks or fewer is a failure.
- R5: Each data mark must total 26 ticks or fewer when its gap begins. 27 or more is a failure.
- R6: When the next mark arrives, a data gap is read as follows: 26 ticks or fewer gives bit 0; 27 to 53 ticks gives bit 1; more than 53 ticks is a failure.
- R7: The first data bit lands in `code[0]` and each later bit goes one position higher. Decoding stops at 32 bits, which takes effect on the mark that ends the 32nd gap. After that, `rec_ready` is 0 and further records change nothing.
- R8: A full 32-bit word gives `code_ok`=1 only if `code[23:16]` XOR `code[31:24]` equals 8'hFF. Bits 15:0 are not checked. Otherwise `code_err`=1.
- R9: On any failure `done`=1, `code_err`=1, `code_ok`=0 and `code`=32'hFFFFFFFF.
- R10: A packet-end pulse before 32 bits are taken is a failure. A record offered in the same cycle as a packet-end pulse is dropped.
- R11: Once `done` is 1, `code`, `code_ok` and `code_err` hold their values until the next packet-start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_start | input | 1 | One-cycle pulse that clears the decoder for a new packet |
| pkt_end | input | 1 | One-cycle pulse meaning the packet has no more records |
| rec_valid | input | 1 | A record is offered |
| rec_level | input | 1 | Record level: 1 = mark, 0 = gap |
| rec_dur | input | 7 | Record length in ticks minus one |
| rec_ready | output | 1 | Decoder accepts records (low once the result is known) |
| done | output | 1 | Result is available |
| code_ok | output | 1 | Frame decoded and the command check passed |
| code_err | output | 1 | Frame failed, or the command check failed |
| code | output | 32 | Decoded word, or all ones on failure |

## Verification
The bench sweeps all 256 command values, each with its true complement and a varying address. This separates bit placement from the complement check. It also sends a corrupted complement for a range of commands and bit positions, so a single wrong bit must flip the result.

Sweeps step the data gap from 1 to 60 ticks and the data mark from 1 to 30 ticks, each on a single bit. These show the exact 26/27 and 53/54 tick edges of R5 and R6. A step of the leading gap across 40/41 ticks shows the R4 edge.

Split records around each edge show that summing is done before comparing. Truncated packets, a packet that starts with a gap, and records sent after completion show the failure and hold rules.

// File: rtl/nec_rl_pkg.sv
package nec_rl_pkg;

    typedef enum logic [2:0] {
        S_LEAD_MARK = 3'd0,
        S_LEAD_GAP  = 3'd1,
        S_BIT_MARK  = 3'd2,
        S_BIT_GAP   = 3'd3,
        S_DONE      = 3'd4
    } dec_state_e;

    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_ADD  = 2'd2
    } acc_op_e;

endpackage

// File: rtl/nec_rl_accum.sv
module nec_rl_accum #(
    parameter int DUR_W   = 7,
    parameter int LEN_W   = 12,
    parameter int PRELOAD = 80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  nec_rl_pkg::acc_op_e  op,
    input  logic [DUR_W-1:0]     dur,
    output logic [LEN_W-1:0]     len
);
    import nec_rl_pkg::*;

    localparam logic [LEN_W:0]   LEN_MAX = {1'b0, {LEN_W{1'b1}}};
    localparam logic [LEN_W-1:0] PRE_V   = LEN_W'(PRELOAD);

    logic [LEN_W:0] ticks;
    logic [LEN_W:0] sum;

    always_comb begin
        ticks = (LEN_W+1)'(dur) + (LEN_W+1)'(1);
        sum   = {1'b0, len} + ticks;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len <= PRE_V;
        end else if (clr) begin
            len <= PRE_V;
        end else begin
            unique case (op)
                ACC_LOAD: len <= ticks[LEN_W-1:0];
                ACC_ADD:  len <= (sum > LEN_MAX) ? LEN_MAX[LEN_W-1:0] : sum[LEN_W-1:0];
                default:  len <= len;
            endcase
        end
    end

    AST_ADD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ACC_ADD && !clr) |=> (len > $past(len) || len == LEN_MAX[LEN_W-1:0])) // R2
        else $error("accumulated length did not grow");

endmodule

// File: rtl/nec_rl_collect.sv
module nec_rl_collect #(
    parameter int NBITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [NBITS-1:0] word_nx,
    output logic             last
);
    localparam int CNT_W = $clog2(NBITS + 1);

    logic [NBITS-1:0] word;
    logic [CNT_W-1:0] count;

    always_comb begin
        word_nx = word | (NBITS'(bit_in) << count);
        last    = (count == CNT_W'(NBITS - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            count <= '0;
        end else if (clr) begin
            word  <= '0;
            count <= '0;
        end else if (shift_en) begin
            word  <= word_nx;
            count <= count + CNT_W'(1);
        end
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(NBITS)) // R7
        else $error("bit count ran past word size");

endmodule

// File: rtl/nec_rl_check.sv
module nec_rl_check #(
    parameter int NBITS   = 32,
    parameter int CMD_LSB = 16
) (
    input  logic [NBITS-1:0] word,
    output logic             ok
);
    localparam int INV_LSB = CMD_LSB + 8;

    always_comb begin
        ok = ((word[CMD_LSB +: 8] ^ word[INV_LSB +: 8]) == 8'hFF);
    end

endmodule

// File: rtl/nec_runlen_decoder.sv
module nec_runlen_decoder #(
    parameter int DUR_W          = 7,
    parameter int LEN_W          = 12,
    parameter int NBITS          = 32,
    parameter int LEAD_PRELOAD   = 80,
    parameter int LEAD_MARK_MIN  = 80,
    parameter int LEAD_GAP_MIN   = 40,
    parameter int BIT_MARK_MAX   = 26,
    parameter int BIT_GAP_MID    = 26,
    parameter int BIT_GAP_MAX    = 53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             pkt_end,
    input  logic             rec_valid,
    input  logic             rec_level,
    input  logic [DUR_W-1:0] rec_dur,
    output logic             rec_ready,
    output logic             done,
    output logic             code_ok,
    output logic             code_err,
    output logic [NBITS-1:0] code
);
    import nec_rl_pkg::*;

    localparam logic [LEN_W-1:0] T_LMARK = LEN_W'(LEAD_MARK_MIN);
    localparam logic [LEN_W-1:0] T_LGAP  = LEN_W'(LEAD_GAP_MIN);
    localparam logic [LEN_W-1:0] T_BMARK = LEN_W'(BIT_MARK_MAX);
    localparam logic [LEN_W-1:0] T_BMID  = LEN_W'(BIT_GAP_MID);
    localparam logic [LEN_W-1:0] T_BGMAX = LEN_W'(BIT_GAP_MAX);

    dec_state_e       state, state_nx;
    acc_op_e          acc_op;
    logic [LEN_W-1:0] len;
    logic             accept;
    logic             ev_fail, ev_fin;
    logic             shift_en, bit_val;
    logic             last_bit;
    logic [NBITS-1:0] word_nx;
    logic             word_ok;

    nec_rl_accum #(
        .DUR_W(DUR_W), .LEN_W(LEN_W), .PRELOAD(LEAD_PRELOAD)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(pkt_start),
        .op(acc_op), .dur(rec_dur), .len(len)
    );

    nec_rl_collect #(.NBITS(NBITS)) u_collect (
        .clk(clk), .rst_n(rst_n), .clr(pkt_start),
        .shift_en(shift_en), .bit_in(bit_val),
        .word_nx(word_nx), .last(last_bit)
    );

    nec_rl_check #(.NBITS(NBITS), .CMD_LSB(16)) u_check (
        .word(word_nx), .ok(word_ok)
    );

    always_comb begin
        rec_ready = (state != S_DONE);
        accept    = rec_valid && rec_ready && !pkt_start && !pkt_end;
    end

    // next-state and datapath control
    always_comb begin
        state_nx = state;
        acc_op   = ACC_HOLD;
        ev_fail  = 1'b0;
        ev_fin   = 1'b0;
        shift_en = 1'b0;
        bit_val  = 1'b0;
        if (pkt_end && state != S_DONE) begin
            ev_fail = 1'b1;                                   // fail
        end else if (accept) begin
            unique case (state)
                S_LEAD_MARK: begin
                    if (rec_level)              acc_op = ACC_ADD;
                    else if (len > T_LMARK) begin
                        acc_op   = ACC_LOAD;
                        state_nx = S_LEAD_GAP;                // lead_ok
                    end else                    ev_fail = 1'b1;
                end
                S_LEAD_GAP: begin
                    if (!rec_level)             acc_op = ACC_ADD;
                    else if (len > T_LGAP) begin
                        acc_op   = ACC_LOAD;
                        state_nx = S_BIT_MARK;                // gap_ok
                    end else                    ev_fail = 1'b1;
                end
                S_BIT_MARK: begin
                    if (rec_level)              acc_op = ACC_ADD;
                    else if (len > T_BMARK)     ev_fail = 1'b1;
                    else begin
                        acc_op   = ACC_LOAD;
                        state_nx = S_BIT_GAP;                 // mark_ok
                    end
                end
                S_BIT_GAP: begin
                    if (!rec_level)             acc_op = ACC_ADD;
                    else if (len > T_BGMAX)     ev_fail = 1'b1;
                    else begin
                        shift_en = 1'b1;
                        bit_val  = (len > T_BMID);
                        if (last_bit) ev_fin = 1'b1;          // word_full
                        else begin
                            acc_op   = ACC_LOAD;
                            state_nx = S_BIT_MARK;            // bit_taken
                        end
                    end
                end
                S_DONE: state_nx = S_DONE;
            endcase
        end
        if (ev_fail || ev_fin) state_nx = S_DONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         state <= S_LEAD_MARK;
        else if (pkt_start) state <= S_LEAD_MARK;               // restart
        else                state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0; code_ok <= 1'b0; code_err <= 1'b0; code <= '0;
        end else if (pkt_start) begin
            done <= 1'b0; code_ok <= 1'b0; code_err <= 1'b0; code <= '0;
        end else if (ev_fail) begin
            done <= 1'b1; code_ok <= 1'b0; code_err <= 1'b1; code <= '1;
        end else if (ev_fin) begin
            done     <= 1'b1;
            code_ok  <= word_ok;
            code_err <= !word_ok;
            code     <= word_ok ? word_nx : '1;
        end
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |=> (!done && !code_ok && !code_err && code == '0)) // R1
        else $error("packet start did not clear result");

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_ok && code_err) && ((code_ok || code_err) == done)) // R8
        else $error("result flags inconsistent");

    AST_OK_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok |-> ((code[23:16] ^ code[31:24]) == 8'hFF)) // R8
        else $error("accepted code fails complement check");

    AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> (code == '1)) // R9
        else $error("failed frame code is not all ones");

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pkt_start) |=> (done && $stable(code) && $stable(code_ok))) // R11
        else $error("result changed before packet start");

    AST_READY_LOW_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rec_ready) // R7
        else $error("records accepted after completion");

endmodule

// File: tb/nec_runlen_decoder_tb.sv
module nec_runlen_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_start = 1'b0, pkt_end = 1'b0;
    logic        rec_valid = 1'b0, rec_level = 1'b0;
    logic [6:0]  rec_dur = '0;
    logic        rec_ready, done, code_ok, code_err;
    logic [31:0] code;

    int checks = 0, failures = 0;
    bit finished = 0;
    int pt[32];
    int st[32];

    always #(CLK_PERIOD/2) clk = ~clk;

    nec_runlen_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
        .rec_valid(rec_valid), .rec_level(rec_level), .rec_dur(rec_dur),
        .rec_ready(rec_ready), .done(done), .code_ok(code_ok),
        .code_err(code_err), .code(code)
    );

    task automatic chk(input string req, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_rec(input logic lvl, input int ticks);
        rec_level = lvl; rec_dur = 7'(ticks - 1); rec_valid = 1'b1;
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic send_run(input logic lvl, input int ticks);
        int left = ticks;
        while (left > 0) begin
            int n = (left > 128) ? 128 : left;
            send_rec(lvl, n);
            left -= n;
        end
    endtask

    task automatic start_pkt();
        pkt_start = 1'b1; @(negedge clk); pkt_start = 1'b0;
    endtask

    task automatic end_pkt();
        pkt_end = 1'b1; @(negedge clk); pkt_end = 1'b0;
    endtask

    task automatic fill(input logic [31:0] w);
        for (int i = 0; i < 32; i++) begin
            pt[i] = 13;
            st[i] = w[i] ? 40 : 13;
        end
    endtask

    // send frame with lead gap lg, first nb bits, optional trailing mark
    task automatic send_frame(input int lg, input int nb, input bit trail);
        start_pkt();
        send_run(1'b1, 342);
        send_run(1'b0, lg);
        for (int i = 0; i < nb; i++) begin
            send_run(1'b1, pt[i]);
            send_run(1'b0, st[i]);
        end
        if (trail) send_run(1'b1, 21);
        end_pkt();
    endtask

    // expected result from requirements
    task automatic expect_frame(input int lg, input string req);
        logic [31:0] w = '0;
        bit bad = (lg <= 40);
        logic ok;
        for (int i = 0; i < 32; i++) begin
            if (pt[i] > 26 || st[i] > 53) bad = 1;
            w[i] = (st[i] > 26);
        end
        ok = !bad && ((w[23:16] ^ w[31:24]) == 8'hFF);
        chk(req, {done, code_ok, code_err, code}, {1'b1, ok, !ok, ok ? w : 32'hFFFFFFFF});
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        chk("R1 reset", {done, code_ok, code_err, rec_ready}, 35'b0001);
        chk("R1 reset code", 35'(code), 35'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 R7: sweep every command with its complement
        for (int c = 0; c < 256; c++) begin
            w = {~8'(c), 8'(c), 8'(c * 7), 8'(c) ^ 8'h5A};
            fill(w);
            send_frame(170, 32, 1);
            expect_frame(170, "R8 R7 command sweep");
        end
        // R8: corrupted complement, one bit wrong
        for (int c = 0; c < 64; c++) begin
            w = {~8'(c * 3) ^ (8'h01 << (c % 8)), 8'(c * 3), 16'h1234};
            fill(w);
            send_frame(170, 32, 1);
            expect_frame(170, "R8 bad complement");
        end
        // R6: data gap sweep on bit 2 (address byte)
        for (int s = 1; s <= 60; s++) begin
            fill(32'h6D92_00F0);
            st[2] = s;
            send_frame(170, 32, 1);
            expect_frame(170, "R6 gap sweep");
        end
        // R5: data mark sweep on bit 9
        for (int p = 1; p <= 30; p++) begin
            fill(32'hAA55_0F0F);
            pt[9] = p;
            send_frame(170, 32, 1);
            expect_frame(170, "R5 mark sweep");
        end
        // R4: lead gap sweep
        for (int g = 36; g <= 46; g++) begin
            fill(32'hE11E_3C3C);
            send_frame(g, 32, 1);
            expect_frame(g, "R4 lead gap sweep");
        end
        // R2: split lead gap 20+20 (40, fail) and 20+21 (41, pass)
        fill(32'hFE01_ABCD);
        start_pkt(); send_run(1, 342); send_rec(0, 20); send_rec(0, 20);
        for (int i = 0; i < 32; i++) begin send_run(1, pt[i]); send_run(0, st[i]); end
        send_run(1, 21);
        chk("R2 split gap 40", {done, code_ok, code_err, code}, {3'b101, 32'hFFFFFFFF});
        start_pkt(); send_run(1, 342); send_rec(0, 20); send_rec(0, 21);
        for (int i = 0; i < 32; i++) begin send_run(1, pt[i]); send_run(0, st[i]); end
        send_run(1, 21);
        chk("R2 split gap 41", {done, code_ok, code_err, code}, {3'b110, 32'hFE01_ABCD});
        // R2: bit-0 gap split 13+14 = 27 ticks -> 1
        start_pkt(); send_run(1, 342); send_run(0, 170);
        send_run(1, 13); send_rec(0, 13); send_rec(0, 14);
        for (int i = 1; i < 32; i++) begin send_run(1, pt[i]); send_run(0, st[i]); end
        send_run(1, 21);
        chk("R2 split data gap", {done, code_ok, code_err, code}, {3'b110, 32'hFE01_ABCD});
        // R3: single one-tick lead mark passes thanks to preload
        start_pkt(); send_rec(1, 1); send_run(0, 170);
        for (int i = 0; i < 32; i++) begin send_run(1, pt[i]); send_run(0, st[i]); end
        send_run(1, 21);
        chk("R3 preload short lead", {done, code_ok, code_err, code}, {3'b110, 32'hFE01_ABCD});
        // R3: packet beginning with a gap fails
        start_pkt(); send_rec(0, 50);
        chk("R3 gap first", {done, code_ok, code_err, code}, {3'b101, 32'hFFFFFFFF});
        // R10: truncated packets
        for (int nb = 0; nb < 32; nb += 5) begin
            fill(32'hFE01_ABCD);
            send_frame(170, nb, 0);
            chk("R10 truncated", {done, code_ok, code_err, code}, {3'b101, 32'hFFFFFFFF});
        end
        // R10: 32 gaps but no closing mark
        send_frame(170, 32, 0);
        chk("R10 no closing mark", {done, code_ok, code_err, code}, {3'b101, 32'hFFFFFFFF});
        // R10: record with pkt_end in same cycle is dropped
        start_pkt();
        rec_level = 1; rec_dur = 7'd50; rec_valid = 1; pkt_end = 1;
        @(negedge clk); rec_valid = 0; pkt_end = 0;
        chk("R10 pkt_end drops record", {done, code_ok, code_err, code}, {3'b101, 32'hFFFFFFFF});
        // R7 R11: records after completion ignored; result held
        fill(32'h33CC_0001);
        send_frame(170, 32, 1);
        chk("R7 ready low", 35'(rec_ready), 35'(0));
        send_run(0, 50); send_run(1, 5); send_run(0, 45);
        repeat (20) @(negedge clk);
        chk("R11 result held", {done, code_ok, code_err, code}, {3'b110, 32'h33CC_0001});
        // R1: pkt_start clears
        start_pkt();
        chk("R1 start clears", {done, code_ok, code_err, code}, 35'h0);
        chk("R1 ready after start", 35'(rec_ready), 35'(1));

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule